// File: doc/BRIEF.md
# ATA Task-File Command Sequencer

This block turns one disk transfer request into the ordered byte writes that load an ATA task file and launch the command. A request carries a drive select bit, a block address, a sector count, a direction (read or write), a transfer mode (DMA or PIO) and an addressing mode (28-bit or 48-bit). The sequencer checks the request against the sector and address limits. It then walks a fixed list of steps and puts each register write on an 8-bit write port. Each write names either a command-block offset (0 to 7) or the separate control register.

In 48-bit mode the upper count and address bytes go out first. This phase is framed by setting and clearing bit 7 of the control register. The lower bytes follow, and the step list ends with the command opcode, which is chosen from mode and direction. After a write command the sequencer waits for a transfer-complete pulse from the data path and then issues a cache flush. Data movement, bus timing, status polling and DMA happen outside this block.

Top module: `tf_cmd_seq`

## Requirements
- R1: After reset, busy, done, err and reg_wr_valid are low and req_ready is high.
- R2: The first write of every accepted request goes to command offset 6 with the value 0xE0 OR (drive << 4).
- R3: In 48-bit mode, after the device select write, the block writes control 0x80, then offset 2 = count[15:8], offset 3 = lba[31:24], offset 4 = lba[39:32], offset 5 = lba[47:40], then control 0x00.
- R4: Next comes offset 2 = count[7:0], then offsets 3, 4 and 5 = lba[7:0], lba[15:8], lba[23:16], then offset 7 = opcode. In 28-bit mode the steps of R3 are left out.
- R5: The opcode for a read is 0x20 (PIO), 0x24 (PIO, 48-bit), 0xC8 (DMA) or 0x25 (DMA, 48-bit). The opcode for a write is 0x30, 0x34, 0xCA or 0x35 in the same order.
- R6: After a write command the block makes no writes and stays busy until xfer_done is high. It then writes offset 7 = 0xEA in 48-bit mode or 0xE7 otherwise. An xfer_done pulse at any other time is ignored.
- R7: At most one write is taken per clock, on a cycle where reg_wr_valid and reg_wr_ready are both high. While the port stalls, the address, data and control flag are held.
- R8: A request with count 0, count above 128, or an address at or above 2^48 makes err pulse for one cycle on the next clock. No register write is made and busy stays low.
- R9: busy rises on accept and falls when the last write is taken. The last write is the read command, or the flush for a write. done pulses on the next clock. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_drive | input | 1 | Drive select bit |
| req_lba | input | LBA_W | Starting block address |
| req_count | input | COUNT_W | Number of sectors |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_dma | input | 1 | 1 = DMA opcode, 0 = PIO opcode |
| req_ext | input | 1 | 1 = 48-bit addressing, 0 = 28-bit |
| xfer_done | input | 1 | Data transfer for a write has completed |
| reg_wr_valid | output | 1 | Register write pending |
| reg_wr_ready | input | 1 | Port takes the pending write this cycle |
| reg_wr_ctl | output | 1 | 1 = control register, 0 = command block |
| reg_wr_addr | output | 3 | Command block offset |
| reg_wr_data | output | 8 | Byte to write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse after the last write |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
A wrong step register shows on the very next accepted write as a wrong offset, a wrong byte or a wrong control flag. A skipped or repeated step changes the number of writes seen before done. A broken wait state shows up in two ways: a flush write before xfer_done, or busy never falling. The bench checks the captured write list against its own model after each request. A broken limit check shows within one clock as a missing err pulse or as writes for a rejected request.

// File: rtl/tf_seq_pkg.sv
// Shared types and constants for the task-file command sequencer.
// Assumes the fixed ATA task-file layout: 48-bit address, 16-bit count.
package tf_seq_pkg;

    // Steps in the order they are issued; increment order is behaviour.
    typedef enum logic [3:0] {
        ST_DEVSEL,
        ST_HOB_ON,
        ST_SC_HI,
        ST_LBA0_HI,
        ST_LBA1_HI,
        ST_LBA2_HI,
        ST_HOB_OFF,
        ST_SC_LO,
        ST_LBA0_LO,
        ST_LBA1_LO,
        ST_LBA2_LO,
        ST_CMD,
        ST_WAIT_XFER,
        ST_FLUSH
    } step_e;

    localparam logic [2:0] OFS_SECT = 3'd2;
    localparam logic [2:0] OFS_LBA0 = 3'd3;
    localparam logic [2:0] OFS_LBA1 = 3'd4;
    localparam logic [2:0] OFS_LBA2 = 3'd5;
    localparam logic [2:0] OFS_DEV  = 3'd6;
    localparam logic [2:0] OFS_CMD  = 3'd7;

    localparam logic [7:0] CTL_HOB_SET = 8'h80;
    localparam logic [7:0] CTL_HOB_CLR = 8'h00;
    localparam logic [7:0] DEV_BASE    = 8'hE0;

    // Captured request
    typedef struct packed {
        logic        drive;
        logic [47:0] lba;
        logic [15:0] count;
        logic        write;
        logic        dma;
        logic        ext;
    } req_t;

    // Transfer opcode picked from direction, mode and addressing
    function automatic logic [7:0] xfer_opcode(input logic wr, input logic dma, input logic ext);
        logic [7:0] op;
        case ({wr, dma, ext})
            3'b000:  op = 8'h20;
            3'b001:  op = 8'h24;
            3'b010:  op = 8'hC8;
            3'b011:  op = 8'h25;
            3'b100:  op = 8'h30;
            3'b101:  op = 8'h34;
            3'b110:  op = 8'hCA;
            default: op = 8'h35;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/tf_req_check.sv
// Request limit check: count must be 1..MAX_SECT and the address must fit
// in ADDR_BITS bits. Purely combinational; assumes LBA_W >= 1.
module tf_req_check #(
    parameter int LBA_W     = 64,
    parameter int COUNT_W   = 9,
    parameter int MAX_SECT  = 128,
    parameter int ADDR_BITS = 48
) (
    input  logic [LBA_W-1:0]   lba,
    input  logic [COUNT_W-1:0] count,
    output logic               ok
);
    logic addr_fits;

    // Upper address bits must be clear when the port is wider than the limit
    generate
        if (LBA_W > ADDR_BITS) begin : g_wide
            assign addr_fits = (lba[LBA_W-1:ADDR_BITS] == '0);
        end else begin : g_narrow
            assign addr_fits = 1'b1;
        end
    endgenerate

    // Combine count range and address range
    always_comb begin
        ok = addr_fits && (count != '0) && (count <= COUNT_W'(MAX_SECT));
    end
endmodule

// File: rtl/tf_step_decode.sv
// Maps the current step and captured request to one register write:
// target (control or command block), offset and byte. Combinational.
module tf_step_decode
    import tf_seq_pkg::*;
(
    input  step_e      step,
    input  req_t       r,
    output logic       is_ctl,
    output logic [2:0] addr,
    output logic [7:0] data
);
    // Select target and byte for the step
    always_comb begin
        is_ctl = 1'b0;
        addr   = OFS_CMD;
        data   = 8'h00;
        case (step)
            ST_DEVSEL:  begin addr = OFS_DEV;  data = DEV_BASE | {3'b000, r.drive, 4'b0000}; end
            ST_HOB_ON:  begin is_ctl = 1'b1; addr = 3'd0; data = CTL_HOB_SET; end
            ST_SC_HI:   begin addr = OFS_SECT; data = r.count[15:8]; end
            ST_LBA0_HI: begin addr = OFS_LBA0; data = r.lba[31:24]; end
            ST_LBA1_HI: begin addr = OFS_LBA1; data = r.lba[39:32]; end
            ST_LBA2_HI: begin addr = OFS_LBA2; data = r.lba[47:40]; end
            ST_HOB_OFF: begin is_ctl = 1'b1; addr = 3'd0; data = CTL_HOB_CLR; end
            ST_SC_LO:   begin addr = OFS_SECT; data = r.count[7:0]; end
            ST_LBA0_LO: begin addr = OFS_LBA0; data = r.lba[7:0]; end
            ST_LBA1_LO: begin addr = OFS_LBA1; data = r.lba[15:8]; end
            ST_LBA2_LO: begin addr = OFS_LBA2; data = r.lba[23:16]; end
            ST_CMD:     begin addr = OFS_CMD;  data = xfer_opcode(r.write, r.dma, r.ext); end
            ST_FLUSH:   begin addr = OFS_CMD;  data = r.ext ? 8'hEA : 8'hE7; end
            default:    begin addr = OFS_CMD;  data = 8'h00; end
        endcase
    end
endmodule

// File: rtl/tf_cmd_seq.sv
// Task-file command sequencer top. Takes one request when idle, rejects it
// if out of limits, else issues the task-file writes one per accepted port
// cycle, waits for xfer_done after a write command, then issues the flush.
// Assumes reg_wr_ready may stall at any time; xfer_done is a level/pulse
// sampled only in the wait step.
module tf_cmd_seq
    import tf_seq_pkg::*;
#(
    parameter int LBA_W     = 64,
    parameter int COUNT_W   = 9,
    parameter int MAX_SECT  = 128,
    parameter int ADDR_BITS = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_drive,
    input  logic [LBA_W-1:0]   req_lba,
    input  logic [COUNT_W-1:0] req_count,
    input  logic               req_write,
    input  logic               req_dma,
    input  logic               req_ext,
    input  logic               xfer_done,
    output logic               reg_wr_valid,
    input  logic               reg_wr_ready,
    output logic               reg_wr_ctl,
    output logic [2:0]         reg_wr_addr,
    output logic [7:0]         reg_wr_data,
    output logic               busy,
    output logic               done,
    output logic               err
);
    step_e step_q;
    step_e step_nx;
    req_t  cur_q;
    req_t  req_in;
    logic  req_ok;
    logic  last_step;

    tf_req_check #(
        .LBA_W(LBA_W), .COUNT_W(COUNT_W), .MAX_SECT(MAX_SECT), .ADDR_BITS(ADDR_BITS)
    ) u_check (
        .lba(req_lba), .count(req_count), .ok(req_ok)
    );

    tf_step_decode u_dec (
        .step(step_q), .r(cur_q),
        .is_ctl(reg_wr_ctl), .addr(reg_wr_addr), .data(reg_wr_data)
    );

    // Pack the incoming request into the captured form
    always_comb begin
        req_in.drive = req_drive;
        req_in.lba   = 48'(req_lba);
        req_in.count = 16'(req_count);
        req_in.write = req_write;
        req_in.dma   = req_dma;
        req_in.ext   = req_ext;
    end

    // Next step and end-of-request detection
    always_comb begin
        case (step_q)
            ST_DEVSEL:  step_nx = cur_q.ext ? ST_HOB_ON : ST_SC_LO;
            ST_CMD:     step_nx = ST_WAIT_XFER;
            ST_FLUSH:   step_nx = ST_FLUSH;
            default:    step_nx = step_e'(step_q + 4'd1);
        endcase
        last_step = (step_q == ST_FLUSH) || ((step_q == ST_CMD) && !cur_q.write);
    end

    assign req_ready    = !busy;
    assign reg_wr_valid = busy && (step_q != ST_WAIT_XFER);

    // Request accept, step advance and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            step_q <= ST_DEVSEL;
            cur_q  <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    if (req_ok) begin
                        busy   <= 1'b1;
                        step_q <= ST_DEVSEL;
                        cur_q  <= req_in;
                    end else begin
                        err <= 1'b1;
                    end
                end
            end else if (step_q == ST_WAIT_XFER) begin
                if (xfer_done) step_q <= ST_FLUSH;
            end else if (reg_wr_ready) begin
                if (last_step) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step_q <= step_nx;
                end
            end
        end
    end
endmodule

// File: rtl/tf_cmd_seq_chk.sv
// Assertion checker for tf_cmd_seq, attached by bind. Observes ports only.
module tf_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       reg_wr_valid,
    input logic       reg_wr_ready,
    input logic       reg_wr_ctl,
    input logic [2:0] reg_wr_addr,
    input logic [7:0] reg_wr_data,
    input logic       done,
    input logic       err
);
    // R9: no writes while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !reg_wr_valid);

    // R7: a stalled write is held unchanged
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid && !reg_wr_ready) |=> (reg_wr_valid && $stable(reg_wr_data)
            && $stable(reg_wr_addr) && $stable(reg_wr_ctl)));

    // R8: a rejection never starts a request nor signals completion
    p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done));

    // R9: done follows an accepted write to offset 7 of the command block
    p_done_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(reg_wr_valid && reg_wr_ready && !reg_wr_ctl
            && reg_wr_addr == 3'd7)));

    // R2: the first write of a request is device select
    p_first_devsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (reg_wr_valid && !reg_wr_ctl && reg_wr_addr == 3'd6));

    // R4/R6: after a command write either the request ends or the port goes quiet
    p_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid && reg_wr_ready && !reg_wr_ctl && reg_wr_addr == 3'd7)
            |=> (done || !reg_wr_valid));
endmodule

bind tf_cmd_seq tf_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_ctl(reg_wr_ctl), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .done(done), .err(err)
);

// File: tb/sim_tf_cmd_seq.sv
// Bench for tf_cmd_seq: directed corners plus seeded random requests,
// each write sequence compared against a list built by bench functions.
module sim_tf_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LBA_W   = 64;
    localparam int COUNT_W = 9;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic               req_drive = 1'b0;
    logic [LBA_W-1:0]   req_lba = '0;
    logic [COUNT_W-1:0] req_count = '0;
    logic               req_write = 1'b0;
    logic               req_dma = 1'b0;
    logic               req_ext = 1'b0;
    logic               xfer_done = 1'b0;
    logic               reg_wr_valid;
    logic               reg_wr_ready = 1'b0;
    logic               reg_wr_ctl;
    logic [2:0]         reg_wr_addr;
    logic [7:0]         reg_wr_data;
    logic               busy;
    logic               done;
    logic               err;

    int tests = 0;
    int fails = 0;

    // expected and captured write lists: {ctl, addr, data}
    logic [11:0] exp_q [16];
    logic [11:0] cap_q [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    tf_cmd_seq #(.LBA_W(LBA_W), .COUNT_W(COUNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_drive(req_drive), .req_lba(req_lba), .req_count(req_count),
        .req_write(req_write), .req_dma(req_dma), .req_ext(req_ext),
        .xfer_done(xfer_done), .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
        .reg_wr_ctl(reg_wr_ctl), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] op_of(input bit w, input bit d, input bit x);
        if (!w) return d ? (x ? 8'h25 : 8'hC8) : (x ? 8'h24 : 8'h20);
        return d ? (x ? 8'h35 : 8'hCA) : (x ? 8'h34 : 8'h30);
    endfunction

    // Build the expected write list; returns its length
    function automatic int build(input bit drv, input logic [47:0] a, input logic [15:0] c,
                                 input bit w, input bit d, input bit x);
        int n = 0;
        exp_q[n++] = {1'b0, 3'd6, 8'hE0 | (8'(drv) << 4)};
        if (x) begin
            exp_q[n++] = {1'b1, 3'd0, 8'h80};
            exp_q[n++] = {1'b0, 3'd2, c[15:8]};
            exp_q[n++] = {1'b0, 3'd3, a[31:24]};
            exp_q[n++] = {1'b0, 3'd4, a[39:32]};
            exp_q[n++] = {1'b0, 3'd5, a[47:40]};
            exp_q[n++] = {1'b1, 3'd0, 8'h00};
        end
        exp_q[n++] = {1'b0, 3'd2, c[7:0]};
        exp_q[n++] = {1'b0, 3'd3, a[7:0]};
        exp_q[n++] = {1'b0, 3'd4, a[15:8]};
        exp_q[n++] = {1'b0, 3'd5, a[23:16]};
        exp_q[n++] = {1'b0, 3'd7, op_of(w, d, x)};
        if (w) exp_q[n++] = {1'b0, 3'd7, x ? 8'hEA : 8'hE7};
        return n;
    endfunction

    // Run one request and compare the captured writes
    task automatic run_req(input bit drv, input logic [LBA_W-1:0] a, input logic [COUNT_W-1:0] c,
                           input bit w, input bit d, input bit x, input bit poke, input bit stray);
        bit good;
        int nexp = 0;
        int nwr = 0;
        int wcnt = 0;
        bit got_done = 0;
        bit got_err = 0;
        bit xsent = 0;
        bit stalled = 0;
        logic [11:0] held = '0;
        good = (c != 0) && (c <= 128) && (a[63:48] == 0);
        if (good) nexp = build(drv, a[47:0], 16'(c), w, d, x);
        for (int cyc = 1; cyc < 500 && !got_done && !got_err; cyc++) begin
            @(negedge clk);
            req_valid = (cyc == 1) || (poke && cyc == 4);
            req_drive = (cyc == 1) ? drv : ~drv;
            req_lba   = (cyc == 1) ? a : ~a;
            req_count = (cyc == 1) ? c : 9'd3;
            req_write = (cyc == 1) ? w : ~w;
            req_dma   = d;
            req_ext   = (cyc == 1) ? x : ~x;
            reg_wr_ready = ($urandom % 4) != 0;
            xfer_done = stray && (cyc == 3);
            if (good && w && !xsent && nwr == nexp - 1) begin
                wcnt++;
                if (wcnt == 6) begin
                    // R6: still waiting, no flush before xfer_done
                    check(busy && !reg_wr_valid, "R6 wait before xfer_done", {busy, reg_wr_valid}, 2'b10);
                    xfer_done = 1'b1;
                    xsent = 1;
                end
            end
            #1;
            if (stalled)
                check(reg_wr_valid && {reg_wr_ctl, reg_wr_addr, reg_wr_data} == held,
                      "R7 hold while stalled", {reg_wr_ctl, reg_wr_addr, reg_wr_data}, held);
            if (reg_wr_valid && reg_wr_ready) begin
                if (nwr < 16) cap_q[nwr] = {reg_wr_ctl, reg_wr_addr, reg_wr_data};
                nwr++;
            end
            stalled = reg_wr_valid && !reg_wr_ready;
            held = {reg_wr_ctl, reg_wr_addr, reg_wr_data};
            if (done) got_done = 1;
            if (err) got_err = 1;
        end
        req_valid = 1'b0;
        xfer_done = 1'b0;
        if (good) begin
            check(got_done && !got_err, "R9 done pulse", {got_done, got_err}, 2'b10);
            check(nwr == nexp, "R3 R4 R6 write count", nwr, nexp);
            for (int i = 0; i < nexp && i < nwr; i++) begin
                if (cap_q[i] != exp_q[i]) begin
                    check(0, $sformatf("R2 R3 R4 R5 write %0d", i), cap_q[i], exp_q[i]);
                    break;
                end
            end
            tests++;
            check(!busy && req_ready, "R9 idle after done", {busy, req_ready}, 2'b01);
        end else begin
            check(got_err && nwr == 0 && !busy, "R8 reject", {got_err, 8'(nwr), busy}, {1'b1, 8'd0, 1'b0});
        end
        // no further writes: poked request while busy was ignored (R9)
        nwr = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            reg_wr_ready = 1'b1;
            #1;
            if (reg_wr_valid) nwr++;
        end
        check(nwr == 0 && !busy, "R9 no write after end", nwr, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #1;
        check(!busy && req_ready && !reg_wr_valid && !done && !err, "R1 held in reset",
              {busy, req_ready, reg_wr_valid, done, err}, 5'b01000);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!busy && req_ready && !reg_wr_valid && !done && !err, "R1 reset state",
              {busy, req_ready, reg_wr_valid, done, err}, 5'b01000);
        // every mode, smallest count (R5)
        for (int m = 0; m < 8; m++)
            run_req(m[0], 64'h0000_1234_5678_9ABC, 9'd1, m[2], m[1], m[0], 1'b0, 1'b0);
        // boundaries: max count, max address (R3, R8)
        run_req(1'b1, 64'h0000_FFFF_FFFF_FFFF, 9'd128, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        run_req(1'b0, 64'h0000_FFFF_FFFF_FFFF, 9'd128, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_req(1'b0, 64'h0, 9'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_req(1'b0, 64'h10, 9'd129, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        run_req(1'b1, 64'h0001_0000_0000_0000, 9'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        // seeded random mix
        for (int t = 0; t < 40; t++) begin
            logic [LBA_W-1:0] a;
            logic [COUNT_W-1:0] c;
            a = {16'h0, 16'($urandom), $urandom};
            c = COUNT_W'(($urandom % 128) + 1);
            if (($urandom % 8) == 0) a[48 + ($urandom % 16)] = 1'b1;
            if (($urandom % 8) == 1) c = COUNT_W'(129 + ($urandom % 100));
            run_req(1'($urandom), a, c, 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule